// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character at a time into an asynchronous serial frame on a single line. A character is offered with a valid/ready handshake. Timing comes from a baud tick that pulses sixteen times per bit, so the block itself only counts ticks. Framing is set by static controls: word length, parity on/off, odd/even selection, constant ("stuck") parity, and a long-stop mode.

A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period. The stop period is one, one and a half or two bit times. The framing controls are captured together with the character. This lets a controller change them freely without corrupting a frame that is already on the line.

Top module: `uart_frame_tx`

## Requirements
- R1: `word_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits go out least significant bit first, taken from the low bits of `in_data`.
- R2: The line is high while idle, low for the start bit and high throughout the stop period.
- R3: With `par_en` = 0, no parity bit is sent, whatever the values of `par_sel` and `par_stick`.
- R4: With `par_en` = 1 and `par_stick` = 0, `par_sel` = 0 gives odd parity and `par_sel` = 1 gives even parity. Parity is taken over the transmitted data bits only.
- R5: With `par_en` = 1 and `par_stick` = 1, the parity bit is the constant 0 when `par_sel` = 1 and the constant 1 when `par_sel` = 0.
- R6: With `stop_mode` = 0, the stop period lasts 16 ticks for every word length.
- R7: With `stop_mode` = 1, the stop period lasts 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words.
- R8: Every start, data and parity bit lasts exactly 16 ticks. The line and the frame progress change only on cycles where `tick16` is high.
- R9: The framing controls are sampled on the clock edge that accepts a character. A change during a frame affects only later frames.
- R10: A character is accepted on a clock edge where `in_valid` and `in_ready` are both high. In the cycle after that edge, `in_ready` is low and the start bit is on the line. `in_ready` rises on the edge that consumes the last stop-bit tick. `busy` is always the inverse of `in_ready`, so a held request starts the next frame at once.
- R11: After reset the line is high, `in_ready` is high and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Baud tick, 16 pulses per bit time, one clock wide |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Transmitter can accept a character |
| in_data | input | 8 | Character, low bits used for short words |
| word_len | input | 2 | Data-bit count code |
| par_en | input | 1 | Parity bit present |
| par_sel | input | 1 | Parity sense select |
| par_stick | input | 1 | Constant parity mode |
| stop_mode | input | 1 | Long stop period |
| ser_out | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |

## Verification
The assertions check several properties on every cycle. The line stays high while idle. An accepted character drops the line and `in_ready` on the next cycle. Neither the line nor the busy state moves on a cycle without a tick. `in_ready` rises only after a tick, and the per-bit tick counter never reaches its limit. The actual frame content can only be shown by the bench's scenarios. This covers data order per word length, odd, even and stuck parity values, the exact tick length of each stop mode, capture of the controls at acceptance, and back-to-back frames. The bench decodes the line at mid-bit tick positions and counts the total ticks of each frame.

// File: rtl/uft_pkg.sv
package uft_pkg;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_START = 3'd1,
      S_DATA  = 3'd2,
      S_PAR   = 3'd3,
      S_STOP  = 3'd4
   } uft_state_t;

   // width of a tick counter able to hold a count up to max_ticks
   function automatic int uft_cnt_w(input int max_ticks);
      return $clog2(max_ticks + 1);
   endfunction

endpackage

// File: rtl/uft_frame_plan.sv
// Derives the shape of one frame from the character and the framing controls.
module uft_frame_plan #(
   parameter int DATA_W = 8,
   parameter int OS     = 16,
   parameter int LEN_W  = uft_pkg::uft_cnt_w(2 * OS)
) (
   input  logic [DATA_W-1:0] data,
   input  logic [1:0]        word_len,
   input  logic              par_en,
   input  logic              par_sel,
   input  logic              par_stick,
   input  logic              stop_mode,
   output logic [3:0]        nbits,
   output logic              has_par,
   output logic              par_bit,
   output logic [LEN_W-1:0]  stop_len
);
   localparam int HALF = OS / 2;

   if (DATA_W != 8) begin : g_bad_data_w
      $error("uft_frame_plan: DATA_W must be 8");
   end
   if ((OS < 2) || ((OS % 2) != 0)) begin : g_bad_os
      $error("uft_frame_plan: OS must be even and at least 2");
   end

   logic [DATA_W-1:0] keep;
   logic [DATA_W-1:0] masked;
   logic              par_calc;

   assign nbits = 4'd5 + {2'b00, word_len};

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign keep[i] = (nbits > 4'(i));
   end

   assign masked   = data & keep;
   assign par_calc = par_sel ? (^masked) : ~(^masked);
   assign has_par  = par_en;
   assign par_bit  = par_stick ? ~par_sel : par_calc;

   always_comb begin
      if (!stop_mode)           stop_len = LEN_W'(OS);
      else if (word_len == 2'b00) stop_len = LEN_W'(OS + HALF);
      else                       stop_len = LEN_W'(2 * OS);
   end

endmodule

// File: rtl/uft_bit_clock.sv
// Counts baud ticks inside one phase of the frame; flags the last tick.
module uft_bit_clock #(
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic [LEN_W-1:0] limit,
   output logic             done
);
   logic [LEN_W-1:0] cnt;

   assign done = tick && (cnt == (limit - LEN_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (restart || done) cnt <= '0;
      else if (tick)          cnt <= cnt + LEN_W'(1);
   end

   // R8: the phase counter never reaches its limit
   a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < limit);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
   parameter int DATA_W = 8,
   parameter int OS     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic [1:0]        word_len,
   input  logic              par_en,
   input  logic              par_sel,
   input  logic              par_stick,
   input  logic              stop_mode,
   output logic              ser_out,
   output logic              busy
);
   import uft_pkg::*;

   localparam int LEN_W = uft_cnt_w(2 * OS);

   uft_state_t        state;
   logic [DATA_W-1:0] shreg;
   logic [3:0]        bits_left;
   logic              pl_par, pl_bit;
   logic [LEN_W-1:0]  pl_stop;

   logic [3:0]        nx_nbits;
   logic              nx_par, nx_bit;
   logic [LEN_W-1:0]  nx_stop;
   logic [LEN_W-1:0]  limit;
   logic              accept, done;

   uft_frame_plan #(.DATA_W(DATA_W), .OS(OS), .LEN_W(LEN_W)) i_plan (
      .data(in_data), .word_len(word_len), .par_en(par_en),
      .par_sel(par_sel), .par_stick(par_stick), .stop_mode(stop_mode),
      .nbits(nx_nbits), .has_par(nx_par), .par_bit(nx_bit), .stop_len(nx_stop)
   );

   assign limit = (state == S_STOP) ? pl_stop : LEN_W'(OS);

   uft_bit_clock #(.LEN_W(LEN_W)) i_clock (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .restart(accept),
      .limit(limit), .done(done)
   );

   assign in_ready = (state == S_IDLE);
   assign busy     = ~in_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         shreg     <= '0;
         bits_left <= '0;
         pl_par    <= 1'b0;
         pl_bit    <= 1'b0;
         pl_stop   <= LEN_W'(OS);
      end else begin
         case (state)
            S_IDLE: if (accept) begin
               shreg     <= in_data;
               bits_left <= nx_nbits;
               pl_par    <= nx_par;
               pl_bit    <= nx_bit;
               pl_stop   <= nx_stop;
               state     <= S_START;
            end
            S_START: if (done) state <= S_DATA;
            S_DATA: if (done) begin
               shreg     <= shreg >> 1;
               bits_left <= bits_left - 4'd1;
               if (bits_left == 4'd1) state <= pl_par ? S_PAR : S_STOP;
            end
            S_PAR:  if (done) state <= S_STOP;
            S_STOP: if (done) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state)
         S_START: ser_out = 1'b0;
         S_DATA:  ser_out = shreg[0];
         S_PAR:   ser_out = pl_bit;
         default: ser_out = 1'b1;
      endcase
   end

   // R2: idle line is high
   a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ser_out);
   // R10: acceptance drops ready and starts the start bit next cycle
   a_r10_accept_start: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (!in_ready && !ser_out));
   // R8: nothing moves without a tick
   a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick16) |=> (busy && $stable(ser_out)));
   // R10: ready returns only on a tick edge
   a_r10_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> $past(tick16));

endmodule

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = 8'h00;
   logic [1:0] word_len = 2'b00;
   logic       par_en = 1'b0, par_sel = 1'b0, par_stick = 1'b0, stop_mode = 1'b0;
   logic       ser_out, busy;

   int checks = 0;
   int failures = 0;
   logic samp [0:511];
   int   nsamp;
   logic expb [0:11];
   int   exp_main;
   int   exp_ticks;

   uart_frame_tx i_uart_frame_tx (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data), .word_len(word_len),
      .par_en(par_en), .par_sel(par_sel), .par_stick(par_stick),
      .stop_mode(stop_mode), .ser_out(ser_out), .busy(busy)
   );

   always #2 clk = ~clk;

   // tick one cycle in three, changed away from the sampling edge
   initial begin
      int div = 0;
      forever begin
         @(posedge clk);
         #1;
         div = (div == 2) ? 0 : div + 1;
         tick16 = (div == 0);
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic set_cfg(input [1:0] wl, input pe, input ps, input st, input sm);
      word_len = wl; par_en = pe; par_sel = ps; par_stick = st; stop_mode = sm;
   endtask

   // expected frame from the requirements
   task automatic plan(input [7:0] d, input [1:0] wl, input pe, input ps, input st, input sm);
      int nb = 5 + int'(wl);
      logic x = 1'b0;
      expb[0] = 1'b0;
      for (int i = 0; i < nb; i++) begin
         expb[1 + i] = d[i];
         x = x ^ d[i];
      end
      if (pe) expb[1 + nb] = st ? ~ps : (ps ? x : ~x);
      exp_main  = 1 + nb + int'(pe);
      exp_ticks = 16 * exp_main + (sm ? ((wl == 2'b00) ? 24 : 32) : 16);
   endtask

   // called just after the accepting edge
   task automatic collect();
      nsamp = 0;
      @(negedge clk);
      check(!in_ready && !ser_out && busy, "R10 accept", {in_ready, ser_out}, 0);
      forever begin
         if (in_ready) break;
         if (tick16) begin
            samp[nsamp] = ser_out;
            nsamp++;
         end
         if (nsamp > 500) break;
         @(negedge clk);
      end
   endtask

   task automatic verify(input string req);
      check(nsamp == exp_ticks, {req, " R8 frame ticks"}, nsamp, exp_ticks);
      if (nsamp == exp_ticks) begin
         check(samp[8] == 1'b0, "R2 start low", samp[8], 0);
         for (int k = 1; k < exp_main; k++)
            check(samp[16 * k + 8] == expb[k], {req, " R1 bit"}, samp[16 * k + 8], expb[k]);
         for (int t = 16 * exp_main; t < nsamp; t++)
            if (samp[t] !== 1'b1) check(1'b0, "R2 stop high", t, 1);
         checks++;
      end
      check(busy == 1'b0, "R10 busy", busy, 0);
   endtask

   task automatic send(input [7:0] d);
      while (!in_ready) @(negedge clk);
      in_data = d; in_valid = 1'b1;
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic t_frame(input [7:0] d, input [1:0] wl, input pe, input ps,
                          input st, input sm, input string req);
      @(negedge clk);
      set_cfg(wl, pe, ps, st, sm);
      send(d);
      collect();
      plan(d, wl, pe, ps, st, sm);
      verify(req);
   endtask

   task automatic t_reset();
      check(ser_out == 1'b1, "R11 line", ser_out, 1);
      check(in_ready == 1'b1 && busy == 1'b0, "R11 ready", in_ready, 1);
   endtask

   // R9: controls changed mid-frame apply only to the next frame
   task automatic t_cfg_change();
      @(negedge clk);
      set_cfg(2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
      send(8'hA7);
      set_cfg(2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
      collect();
      plan(8'hA7, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
      verify("R9");
      t_frame(8'h5A, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R9 next");
   endtask

   // R10: held request starts the next frame immediately
   task automatic t_back_to_back();
      @(negedge clk);
      set_cfg(2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
      while (!in_ready) @(negedge clk);
      in_data = 8'h3C; in_valid = 1'b1;
      @(posedge clk);
      #1 in_data = 8'h41;
      collect();
      plan(8'h3C, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
      verify("R10 first");
      @(posedge clk);
      #1 in_valid = 1'b0;
      collect();
      plan(8'h41, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
      verify("R10 second");
   endtask

   initial begin
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_frame(8'hD3, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R6 default");
      t_frame(8'hB5, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, "R4 even");
      t_frame(8'h6B, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, "R4 odd");
      t_frame(8'h2F, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, "R5 stick0");
      t_frame(8'h00, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, "R5 stick1");
      t_frame(8'h95, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, "R3 no parity");
      t_frame(8'h1E, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R7 long5");
      t_frame(8'hC4, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, "R7 long6");
      t_frame(8'h81, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, "R7 long8");
      t_cfg_change();
      t_back_to_back();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule